// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer whose write side and read side each run on their own clock. Writers push words on the write clock and readers pull them on the read clock. The block reports its fill state through five active-low flags: full, empty, half-full, and a pair of almost-full and almost-empty warnings. The two warning thresholds are set at run time.

Both thresholds sit in a pair of 12-bit offset registers. While the shared `load_n` control is low, the ordinary data ports reach these registers instead of the buffer. A write access stores the low 12 input bits. A read access returns the stored value on the low 12 output bits. Accesses alternate between the two registers, always starting with the almost-empty offset. Pointers cross between the clock domains as Gray codes through two-flop synchronizers. Each side therefore sees the other side's progress a couple of its own clock cycles late, and it sees that progress conservatively.

Top module: `dc_flag_fifo`

## Requirements
- R1: While `rst_n` is low, both pointers return to the first location. `full_n`, `afull_n` and `half_n` are high, `empty_n` and `aempty_n` are low, `dout` is zero, and both offsets return to `DEF_OFS` (127).
- R2: With `wr_en_n` low and `load_n` high, each rising `wr_clk` edge appends `din` when `full_n` is high. A write attempted while `full_n` is low is dropped and never appears at the output.
- R3: With `rd_en_n` low and `load_n` high, each rising `rd_clk` edge loads the oldest word into `dout` when `empty_n` is high. A read attempted while `empty_n` is low leaves `dout` unchanged.
- R4: With `rd_en_n` high, `dout` holds its value.
- R5: With `load_n` low and `wr_en_n` low, each `wr_clk` edge stores `din[11:0]` into an offset register and leaves the buffer contents untouched. The first access goes to the almost-empty offset and the next to the almost-full offset, and the two keep alternating. The order restarts at almost-empty whenever `load_n` is high.
- R6: With `load_n` low and `rd_en_n` low, each `rd_clk` edge puts the selected offset on `dout`, zero-extended from 12 bits. The selection order is the same as in R5.
- R7: `aempty_n` is low exactly when the fill level is at or below the almost-empty offset.
- R8: `afull_n` is low exactly when the free space (`DEPTH` minus fill level) is at or below the almost-full offset.
- R9: `half_n` is low exactly when the fill level exceeds `DEPTH`/2.
- R10: `full_n` is low exactly when the fill level equals `DEPTH`, as seen on the write clock. `empty_n` is low exactly when the fill level is zero, as seen on the read clock. Both flags settle within three edges of their own clock after the other side goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write-side clock |
| wr_en_n | input | 1 | Active-low write strobe |
| din | input | 18 | Write data, or offset value on bits 11:0 while loading |
| rd_clk | input | 1 | Read-side clock |
| rd_en_n | input | 1 | Active-low read strobe |
| load_n | input | 1 | Active-low selector routing both ports to the offset registers |
| dout | output | 18 | Registered read data or offset readback |
| full_n | output | 1 | Low when full (write-clock domain) |
| empty_n | output | 1 | Low when empty (read-clock domain) |
| afull_n | output | 1 | Low when free space is at or below the almost-full offset |
| aempty_n | output | 1 | Low when fill level is at or below the almost-empty offset |
| half_n | output | 1 | Low when more than half the entries are occupied |

## Verification
A corrupted write pointer or synchronizer stage shows up at the ports on the next read as a word out of order, or as a wrong flag once both domains have settled, which takes no more than a few clock edges. A wrong offset select bit appears on the very next readback access as the other register's value. An off-by-one in a flag comparison is only visible at the exact boundary fill levels, so the bench stops at each threshold and one entry past it.

// File: rtl/dc_flag_fifo.sv
module dc_flag_fifo #(
  parameter int WIDTH   = 18,
  parameter int DEPTH   = 1024,
  parameter int OFS_W   = 12,
  parameter int DEF_OFS = 127
) (
  input  logic             rst_n,
  input  logic             wr_clk,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] din,
  input  logic             rd_clk,
  input  logic             rd_en_n,
  input  logic             load_n,
  output logic [WIDTH-1:0] dout,
  output logic             full_n,
  output logic             empty_n,
  output logic             afull_n,
  output logic             aempty_n,
  output logic             half_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CW = (PW > OFS_W) ? PW : OFS_W;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, wgray, rq1, rq2;
  logic [PW-1:0]    rptr, rgray, wq1, wq2;
  logic [OFS_W-1:0] ae_ofs, af_ofs;
  logic             wsel, rsel;

  wire              wr_go  = !wr_en_n && load_n && full_n;
  wire              rd_go  = !rd_en_n && load_n && empty_n;
  wire [PW-1:0]     wnext  = wptr + 1'b1;
  wire [PW-1:0]     rnext  = rptr + 1'b1;
  wire [PW-1:0]     wcount = wptr - g2b(rq2);
  wire [PW-1:0]     wspace = PW'(DEPTH) - wcount;
  wire [PW-1:0]     rcount = g2b(wq2) - rptr;

  assign full_n   = wcount != PW'(DEPTH);
  assign afull_n  = !(CW'(wspace) <= CW'(af_ofs));
  assign half_n   = !(wcount > PW'(DEPTH / 2));
  assign empty_n  = rcount != '0;
  assign aempty_n = !(CW'(rcount) <= CW'(ae_ofs));

  always_ff @(posedge wr_clk)
    if (wr_go) mem[wptr[AW-1:0]] <= din;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      wgray  <= '0;
      rq1    <= '0;
      rq2    <= '0;
      ae_ofs <= OFS_W'(DEF_OFS);
      af_ofs <= OFS_W'(DEF_OFS);
      wsel   <= 1'b0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr_go) begin
        wptr  <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
      if (load_n) wsel <= 1'b0;
      else if (!wr_en_n) begin
        if (wsel) af_ofs <= din[OFS_W-1:0];
        else      ae_ofs <= din[OFS_W-1:0];
        wsel <= ~wsel;
      end
    end
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      rgray <= '0;
      wq1   <= '0;
      wq2   <= '0;
      rsel  <= 1'b0;
      dout  <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (rd_go) begin
        dout  <= mem[rptr[AW-1:0]];
        rptr  <= rnext;
        rgray <= rnext ^ (rnext >> 1);
      end
      if (load_n) rsel <= 1'b0;
      else if (!rd_en_n) begin
        dout <= WIDTH'(rsel ? af_ofs : ae_ofs);
        rsel <= ~rsel;
      end
    end
  end
endmodule

// File: rtl/dc_flag_fifo_sva.sv
module dc_flag_fifo_sva #(
  parameter int WIDTH = 18,
  parameter int PW    = 11
) (
  input logic             rst_n,
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             wr_en_n,
  input logic             rd_en_n,
  input logic             load_n,
  input logic [PW-1:0]    wptr,
  input logic [WIDTH-1:0] dout,
  input logic             full_n,
  input logic             empty_n,
  input logic             afull_n,
  input logic             aempty_n,
  input logic             half_n
);
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && !wr_en_n && load_n) |=> $stable(wptr)); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && !rd_en_n && load_n) |=> $stable(dout)); // R3
  AST_HOLD_IDLE: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_en_n |=> $stable(dout)); // R4
  AST_EMPTY_IMPLIES_AE: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n); // R7
  AST_FULL_IMPLIES_AF: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !afull_n); // R8
  AST_FULL_IMPLIES_HALF: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !half_n); // R9
  AST_RESET_FLAGS: assert property (@(posedge wr_clk)
    !rst_n |-> (full_n && afull_n && half_n)); // R1
endmodule

bind dc_flag_fifo dc_flag_fifo_sva #(.WIDTH(WIDTH), .PW(PW)) i_sva (
  .rst_n(rst_n), .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_en_n(wr_en_n),
  .rd_en_n(rd_en_n), .load_n(load_n), .wptr(wptr), .dout(dout),
  .full_n(full_n), .empty_n(empty_n), .afull_n(afull_n),
  .aempty_n(aempty_n), .half_n(half_n)
);

// File: tb/test_dc_flag_fifo.sv
module test_dc_flag_fifo;
  localparam int W = 18;
  localparam int D = 1024;

  logic rst_n = 1'b0, wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_en_n = 1'b1, rd_en_n = 1'b1, load_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic full_n, empty_n, afull_n, aempty_n, half_n;

  dc_flag_fifo i_dc_flag_fifo (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en_n(wr_en_n), .din(din),
    .rd_clk(rd_clk), .rd_en_n(rd_en_n), .load_n(load_n), .dout(dout),
    .full_n(full_n), .empty_n(empty_n), .afull_n(afull_n),
    .aempty_n(aempty_n), .half_n(half_n)
  );

  always #5 wr_clk = ~wr_clk;
  always #7 rd_clk = ~rd_clk;

  int checks = 0, errors = 0;
  logic [W-1:0] q[$];
  logic [W-1:0] last = '0;
  int ae = 127, af = 127;
  int seq = 0;
  bit done = 0;

  // {writes, reads, expected fill}
  localparam logic [35:0] PH [6] = '{
    {12'd200, 12'd0,    12'd200},
    {12'd0,   12'd50,   12'd150},
    {12'd400, 12'd0,    12'd550},
    {12'd350, 12'd0,    12'd900},
    {12'd200, 12'd0,    12'd1024},
    {12'd0,   12'd1030, 12'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
    repeat (2) @(negedge rd_clk);
  endtask

  task automatic check_flags();
    int c = q.size();
    chk(full_n == (c != D), "R10 full_n", full_n, c != D);
    chk(empty_n == (c != 0), "R10 empty_n", empty_n, c != 0);
    chk(aempty_n == !(c <= ae), "R7 aempty_n", aempty_n, !(c <= ae));
    chk(afull_n == !((D - c) <= af), "R8 afull_n", afull_n, !((D - c) <= af));
    chk(half_n == !(c > D / 2), "R9 half_n", half_n, !(c > D / 2));
  endtask

  task automatic do_writes(input int n);
    @(negedge wr_clk);
    wr_en_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      din = W'(seq * 37 + 5);
      seq++;
      if (q.size() < D) q.push_back(din); // R2: writes while full are dropped
      @(negedge wr_clk);
    end
    wr_en_n = 1'b1;
  endtask

  task automatic do_reads(input int n);
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      if (q.size() > 0) begin
        last = q.pop_front();
        chk(dout == last, "R3 read order", dout, last);
      end else
        chk(dout == last, "R3 hold on empty read", dout, last);
    end
    rd_en_n = 1'b1;
  endtask

  task automatic load_ofs(input logic [W-1:0] a, input logic [W-1:0] b, input bit two);
    @(negedge wr_clk);
    load_n = 1'b0; wr_en_n = 1'b0; din = a;
    @(negedge wr_clk);
    if (two) begin
      din = b;
      @(negedge wr_clk);
    end
    wr_en_n = 1'b1; load_n = 1'b1;
    @(negedge wr_clk);
  endtask

  task automatic read_ofs(input int exp_ae, input int exp_af);
    @(negedge rd_clk);
    load_n = 1'b0; rd_en_n = 1'b0;
    @(negedge rd_clk);
    chk(dout == W'(exp_ae), "R6 readback empty offset", dout, exp_ae);
    @(negedge rd_clk);
    chk(dout == W'(exp_af), "R6 readback full offset", dout, exp_af);
    rd_en_n = 1'b1; load_n = 1'b1;
    last = dout;
    @(negedge rd_clk);
    chk(dout == last, "R4 hold after readback", dout, last);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #23;
    chk(full_n && afull_n && half_n, "R1 write flags in reset", {full_n, afull_n, half_n}, 3'b111);
    chk(!empty_n && !aempty_n, "R1 read flags in reset", {empty_n, aempty_n}, 2'b00);
    chk(dout == '0, "R1 dout in reset", dout, 0);
    rst_n = 1'b1;
    settle();
    check_flags();
    read_ofs(127, 127); // R1 default offsets

    for (int p = 0; p < 6; p++) begin
      do_writes(int'(PH[p][35:24]));
      do_reads(int'(PH[p][23:12]));
      settle();
      chk(q.size() == int'(PH[p][11:0]), "R2 model fill", q.size(), PH[p][11:0]);
      check_flags();
    end

    // R5: offsets programmed with high bits set; FIFO stays empty
    load_ofs(18'h3F00A, 18'h2A014, 1'b1);
    ae = 10; af = 20;
    settle();
    chk(!empty_n, "R5 offset load leaves FIFO empty", empty_n, 0);
    read_ofs(10, 20);

    // R5: order restarts after load_n returns high
    load_ofs(18'd9, 18'd0, 1'b0);
    load_ofs(18'd10, 18'd0, 1'b0);
    read_ofs(10, 20);

    // R7 boundary
    do_writes(10); settle();
    chk(!aempty_n, "R7 at threshold", aempty_n, 0);
    check_flags();
    do_writes(1); settle();
    chk(aempty_n, "R7 one above threshold", aempty_n, 1);
    check_flags();

    // R8 boundary
    do_writes(D - 21 - q.size()); settle();
    chk(afull_n, "R8 one below threshold", afull_n, 1);
    check_flags();
    do_writes(1); settle();
    chk(!afull_n, "R8 at threshold", afull_n, 0);
    check_flags();

    // R9 boundary
    do_reads(q.size() - D / 2); settle();
    chk(half_n, "R9 exactly half", half_n, 1);
    do_writes(1); settle();
    chk(!half_n, "R9 one over half", half_n, 0);
    check_flags();

    // R4: idle read clock keeps output
    last = dout;
    repeat (5) @(negedge rd_clk);
    chk(dout == last, "R4 idle hold", dout, last);

    // R1: reset in the middle of operation
    @(negedge wr_clk);
    rst_n = 1'b0;
    #20;
    chk(full_n && afull_n && half_n && !empty_n && !aempty_n, "R1 mid-run reset flags",
        {full_n, afull_n, half_n, empty_n, aempty_n}, 5'b11100);
    chk(dout == '0, "R1 mid-run reset dout", dout, 0);
    rst_n = 1'b1;
    q.delete(); ae = 127; af = 127; last = '0;
    settle();
    check_flags();
    read_ofs(127, 127);
    do_writes(3);
    settle();
    do_reads(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule